// File: doc/BRIEF.md
# Fine-Correction Time-of-Day Counter

This block keeps a time-of-day value split into a 32-bit seconds count and a 31-bit subsecond count. It runs on a fast reference clock. Each reference cycle adds a 32-bit fractional addend into a 32-bit phase accumulator. A carry out of that accumulator advances the subsecond count by a programmable step, and a subsecond wrap advances the seconds.

The addend sets the average carry rate: carries arrive at f_ref * addend / 2^32 per second. An addend of 2^32 / (f_ref / 50 MHz) gives a nominal 50 MHz tick with a 43-unit step, which is about 20 ns resolution. Some examples:
- 0xC1F07C1F for a 66 MHz reference.
- 0xC4EC4EC4 for 65 MHz.
- 0xBF0B7672 for 67 MHz.

Software trims drift by writing a new addend and applying it. It never has to touch the step.

Software also writes preset registers for seconds and subseconds and fires an initialise strobe to load them. It reads the time through a snapshot request, which returns a coherent pair.

Top module: `ptp_fine_clock`

## Requirements
- R1: After reset the seconds, subseconds and accumulator are zero, snap_valid is low, the step is 43, and both the pending and active addend hold 0xC1F07C1F.
- R2: On every clock edge the active addend is added to the accumulator modulo 2^32. When that addition carries out, the subsecond count grows by the step at the same edge. For example, after an initialise, 1320 edges at 0xC1F07C1F, 1300 edges at 0xC4EC4EC4, or 1340 edges at 0xBF0B7672 each give exactly 999 carries.
- R3: When subseconds plus the step would exceed 0x7FFFFFFF, the subsecond count becomes that sum minus 2^31. The seconds count rises by one at the same edge.
- R4: Seconds at 0xFFFFFFFF wrap to 0 on a subsecond rollover.
- R5: A write on addend_wr only changes the pending addend. The running time keeps advancing at the old rate until an apply.
- R6: addend_apply copies the pending addend into the active addend. The new value is used from the next edge on, and the accumulator value is carried over unchanged. An active addend of 0 freezes the time.
- R7: A write on incr_wr sets the step, which is used from the following edge.
- R8: init_go loads seconds and subseconds from the preset registers and clears the accumulator. It overrides any carry in that cycle.
- R9: snap_req raises snap_valid for one cycle after the next edge. snap_sec and snap_sub then hold the seconds and subseconds that stood just before that edge.
- R10: Writes to the preset registers (upd_sec_wr, upd_sub_wr, where the subsecond preset takes upd_wdata[30:0]) have no effect on the running time without init_go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | reference clock |
| rst_n | input | 1 | active-low synchronous reset |
| addend_wr | input | 1 | write pending addend |
| addend_wdata | input | 32 | addend value |
| addend_apply | input | 1 | copy pending addend to active |
| incr_wr | input | 1 | write step |
| incr_wdata | input | INC_W | step value |
| upd_sec_wr | input | 1 | write seconds preset |
| upd_sub_wr | input | 1 | write subseconds preset |
| upd_wdata | input | 32 | preset data |
| init_go | input | 1 | load time from presets |
| snap_req | input | 1 | request a time snapshot |
| time_sec | output | 32 | live seconds |
| time_sub | output | 31 | live subseconds |
| snap_valid | output | 1 | snapshot ready |
| snap_sec | output | 32 | snapshot seconds |
| snap_sub | output | 31 | snapshot subseconds |

## Verification
The accumulator is exercised with three kinds of addend:
- The three nominal drift addends, run for fixed windows. These separate exact carry counting from an off-by-one in carry detection.
- 0x80000000 and 0xFFFFFFFF, which give regular or back-to-back carries. These expose a step applied on the wrong edge.
- Zero, which must freeze the time. This shows whether a pending addend leaks in before its apply.

Presets just below the subsecond and seconds limits tell a correct wrap and same-edge seconds carry from a saturating or late one. Snapshots taken across such a rollover show whether the returned pair is coherent.

// File: rtl/ptp_fine_clock.sv
module ptp_fine_clock #(
  parameter int INC_W = 8,
  parameter logic [31:0] DEF_ADDEND = 32'hC1F07C1F,
  parameter logic [INC_W-1:0] DEF_INC = INC_W'(43)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addend_wr,
  input  logic [31:0]      addend_wdata,
  input  logic             addend_apply,
  input  logic             incr_wr,
  input  logic [INC_W-1:0] incr_wdata,
  input  logic             upd_sec_wr,
  input  logic             upd_sub_wr,
  input  logic [31:0]      upd_wdata,
  input  logic             init_go,
  input  logic             snap_req,
  output logic [31:0]      time_sec,
  output logic [30:0]      time_sub,
  output logic             snap_valid,
  output logic [31:0]      snap_sec,
  output logic [30:0]      snap_sub
);
  localparam int SUB_W = 31;

  logic [31:0]      add_pend, add_act, acc, upd_sec;
  logic [SUB_W-1:0] upd_sub;
  logic [INC_W-1:0] inc;

  wire [32:0]    acc_sum = {1'b0, acc} + {1'b0, add_act};
  wire           tick    = acc_sum[32];
  wire [SUB_W:0] sub_sum = {1'b0, time_sub} + {{(SUB_W+1-INC_W){1'b0}}, inc};
  wire           roll    = tick & sub_sum[SUB_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      add_pend <= DEF_ADDEND;
      add_act  <= DEF_ADDEND;
      inc      <= DEF_INC;
      upd_sec  <= '0;
      upd_sub  <= '0;
    end else begin
      if (addend_wr)    add_pend <= addend_wdata;
      if (addend_apply) add_act  <= add_pend;
      if (incr_wr)      inc      <= incr_wdata;
      if (upd_sec_wr)   upd_sec  <= upd_wdata;
      if (upd_sub_wr)   upd_sub  <= upd_wdata[SUB_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      time_sec <= '0;
      time_sub <= '0;
    end else if (init_go) begin
      acc      <= '0;
      time_sec <= upd_sec;
      time_sub <= upd_sub;
    end else begin
      acc <= acc_sum[31:0];
      if (tick) time_sub <= sub_sum[SUB_W-1:0];
      if (roll) time_sec <= time_sec + 32'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_valid <= 1'b0;
      snap_sec   <= '0;
      snap_sub   <= '0;
    end else begin
      snap_valid <= snap_req;
      if (snap_req) begin
        snap_sec <= time_sec;
        snap_sub <= time_sub;
      end
    end
  end
endmodule

// File: rtl/ptp_fine_clock_chk.sv
module ptp_fine_clock_chk #(parameter int INC_W = 8) (
  input logic             clk,
  input logic             rst_n,
  input logic             addend_apply,
  input logic             init_go,
  input logic             snap_req,
  input logic [31:0]      time_sec,
  input logic [30:0]      time_sub,
  input logic             snap_valid,
  input logic [31:0]      snap_sec,
  input logic [30:0]      snap_sub,
  input logic [31:0]      add_act,
  input logic [31:0]      upd_sec,
  input logic [30:0]      upd_sub,
  input logic [INC_W-1:0] inc
);
  logic [30:0] prev_sub;
  always_ff @(posedge clk) prev_sub <= time_sub;
  wire [30:0] step    = time_sub - prev_sub;
  wire [30:0] inc_ext = {{(31-INC_W){1'b0}}, inc};

  // R2
  sub_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_go |=> (step == 31'd0) || (step == $past(inc_ext)));

  // R3
  sec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_go |=> (time_sec == $past(time_sec)) ? (time_sub >= $past(time_sub))
                                               : (time_sec == $past(time_sec) + 32'd1 && time_sub < $past(time_sub)));

  // R6
  addend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addend_apply |=> $stable(add_act));

  // R8
  init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_go |=> time_sec == $past(upd_sec) && time_sub == $past(upd_sub));

  // R9
  snap_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> snap_valid && snap_sec == $past(time_sec) && snap_sub == $past(time_sub));

  // R9
  snap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_req |=> !snap_valid);
endmodule

bind ptp_fine_clock ptp_fine_clock_chk #(.INC_W(INC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addend_apply(addend_apply), .init_go(init_go),
  .snap_req(snap_req), .time_sec(time_sec), .time_sub(time_sub),
  .snap_valid(snap_valid), .snap_sec(snap_sec), .snap_sub(snap_sub),
  .add_act(add_act), .upd_sec(upd_sec), .upd_sub(upd_sub), .inc(inc)
);

// File: tb/sim_ptp_fine_clock.sv
module sim_ptp_fine_clock;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic addend_wr = 0, addend_apply = 0, incr_wr = 0, upd_sec_wr = 0, upd_sub_wr = 0;
  logic init_go = 0, snap_req = 0;
  logic [31:0] addend_wdata = 0, upd_wdata = 0;
  logic [7:0]  incr_wdata = 0;
  logic [31:0] time_sec, snap_sec;
  logic [30:0] time_sub, snap_sub;
  logic snap_valid;

  ptp_fine_clock u0 (.*);

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model built from the requirements
  logic [31:0] m_pend, m_act, m_acc, m_sec, m_usec;
  logic [30:0] m_sub, m_usub;
  logic [7:0]  m_inc;
  logic [62:0] sb_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 32'hC1F07C1F; m_act = 32'hC1F07C1F; m_acc = 0;
      m_sec = 0; m_sub = 0; m_inc = 8'd43; m_usec = 0; m_usub = 0;
    end else begin
      logic [32:0] s;
      logic [31:0] ss;
      logic [31:0] n_pend, n_act, n_usec;
      logic [30:0] n_usub;
      logic [7:0]  n_inc;
      if (snap_req) sb_q.push_back({m_sec, m_sub});
      n_pend = addend_wr ? addend_wdata : m_pend;
      n_act  = addend_apply ? m_pend : m_act;
      n_inc  = incr_wr ? incr_wdata : m_inc;
      n_usec = upd_sec_wr ? upd_wdata : m_usec;
      n_usub = upd_sub_wr ? upd_wdata[30:0] : m_usub;
      if (init_go) begin
        m_acc = 0; m_sec = m_usec; m_sub = m_usub;
      end else begin
        s = {1'b0, m_acc} + {1'b0, m_act};
        m_acc = s[31:0];
        if (s[32]) begin
          ss = {1'b0, m_sub} + {24'd0, m_inc};
          if (ss[31]) m_sec = m_sec + 1;
          m_sub = ss[30:0];
        end
      end
      m_pend = n_pend; m_act = n_act; m_inc = n_inc; m_usec = n_usec; m_usub = n_usub;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_live(string req);
    chk(req, {time_sec, 1'b0, time_sub}, {m_sec, 1'b0, m_sub});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && snap_valid) begin
      if (sb_q.size() == 0) chk("R9", 64'd1, 64'd0);
      else begin
        logic [62:0] e;
        e = sb_q.pop_front();
        chk("R9", {snap_sec, 1'b0, snap_sub}, {e[62:31], 1'b0, e[30:0]});
      end
    end
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic snap();
    snap_req = 1; cyc(1); snap_req = 0;
  endtask

  task automatic set_addend(logic [31:0] v, bit apply);
    addend_wdata = v; addend_wr = 1; cyc(1); addend_wr = 0;
    if (apply) begin addend_apply = 1; cyc(1); addend_apply = 0; end
  endtask

  task automatic preset(logic [31:0] s, logic [30:0] ss);
    upd_wdata = s; upd_sec_wr = 1; cyc(1); upd_sec_wr = 0;
    upd_wdata = {1'b0, ss}; upd_sub_wr = 1; cyc(1); upd_sub_wr = 0;
  endtask

  task automatic do_init(); init_go = 1; cyc(1); init_go = 0; endtask

  task automatic set_inc(logic [7:0] v);
    incr_wdata = v; incr_wr = 1; cyc(1); incr_wr = 0;
  endtask

  initial begin
    cyc(3);
    // R1 reset state
    chk("R1", {time_sec, 1'b0, time_sub}, 64'd0);
    chk("R1", {63'd0, snap_valid}, 64'd0);
    rst_n = 1;
    cyc(1);
    snap();

    // R2 three nominal addends, 999 carries each
    preset(0, 0); do_init(); cyc(1320);
    chk("R2", {33'd0, time_sub}, 64'd999 * 43);
    set_addend(32'hC4EC4EC4, 1); do_init(); cyc(1300);
    chk("R2", {33'd0, time_sub}, 64'd999 * 43);
    set_addend(32'hBF0B7672, 1); do_init(); cyc(1340);
    chk("R2", {33'd0, time_sub}, 64'd999 * 43);
    chk_live("R2");
    snap();

    // R2 half-rate carries
    set_addend(32'h80000000, 1); cyc(37); chk_live("R2");

    // R5 pending addend has no effect before apply
    set_addend(32'h0, 0); cyc(20); chk_live("R5");
    chk("R5", {63'd0, (time_sub != 0 || time_sec != 0)}, 64'd1);

    // R6 zero addend freezes time
    addend_apply = 1; cyc(1); addend_apply = 0;
    begin
      logic [62:0] held;
      held = {time_sec, time_sub};
      cyc(25);
      chk("R6", {1'b0, time_sec, time_sub}, {1'b0, held});
    end
    // R6 accumulator carried over across apply
    set_addend(32'h40000000, 1); cyc(13); chk_live("R6");

    // R7 step change
    set_inc(8'd100); cyc(19); chk_live("R7");
    snap();

    // R10 preset writes alone do not move time
    preset(32'h1234, 31'h55); cyc(5); chk_live("R10");

    // R3 subsecond wrap raises seconds on the same edge
    set_inc(8'd200);
    set_addend(32'hFFFFFFFF, 1);
    preset(5, 31'h7FFFFF00); do_init();
    cyc(2);
    chk("R3", {time_sec, 1'b0, time_sub}, {32'd5, 1'b0, 31'h7FFFFF00 + 31'd200});
    cyc(1);
    chk("R3", {time_sec, 1'b0, time_sub}, {32'd6, 1'b0, 31'd144});

    // R4 seconds wrap to zero; R9 snapshot around the rollover
    preset(32'hFFFFFFFF, 31'h7FFFFF00); do_init();
    snap(); snap(); snap();
    chk("R4", {time_sec, 1'b0, time_sub}, {32'd0, 1'b0, 31'd144});

    // R8 init clears accumulator and wins over a carry
    set_addend(32'h9E3779B9, 1); cyc(7);
    preset(77, 31'd1000);
    init_go = 1; cyc(1); init_go = 0;
    chk("R8", {time_sec, 1'b0, time_sub}, {32'd77, 1'b0, 31'd1000});
    cyc(31); chk_live("R8");
    snap(); cyc(2);

    chk("R9", {32'd0, 32'(sb_q.size())}, 64'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule